// File: doc/BRIEF.md
# Sinusoidal PWM H-Bridge Gate Driver

This block drives the four switches of a full H-bridge so that the bridge output, once averaged by an external filter, follows a sine wave. It walks a computed signed sine table one entry per carrier period and scales each entry by an unsigned amplitude fraction. The result is a signed control value. A free-running counter, re-centred around zero, forms the sawtooth carrier. The first arm compares the control value against the carrier. The second arm compares the negated control value against the same carrier. Within each arm the low-side switch is the complement of the high-side switch. Because of this, the two arms' duty cycles always add to one. The bridge delivers positive voltage only while the first arm's high side and the second arm's low side overlap, and that overlap sits in the middle of the carrier period.

Each arm passes its comparison through a dead-time state machine. The machine has five states. `G_OFF` means both gates are off (disabled). `G_LO` means the low gate is on. `G_HI` means the high gate is on. `G_DT_HI` and `G_DT_LO` are dead states, with both gates off, on the way to high or to low. The transitions work as follows:
- Disable takes any state to `G_OFF`.
- `G_OFF` goes to the dead state toward the requested side.
- A change of request in `G_LO` moves to `G_DT_HI`, and a change of request in `G_HI` moves to `G_DT_LO`.
- A dead state moves to its target side when its counter expires.
- If the request reverts during a dead state, the machine returns at once to the side it came from.

A strobe marks the first clock of each output cycle. Clearing enable parks the bridge with all switches open and rewinds the sequence.

Top module: `spwm_hbridge`

## Requirements
- R1: While reset is asserted or `en` is low, all four gate outputs are 0 and the table position returns to entry 0. The first clock after `en` is raised again is the first clock of output cycle entry 0, so `cyc_start` is 1 in that clock. Gates go to 0 on the first clock edge after `en` falls.
- R2: Table entry k of Q (default Q = 40) is computed from x = floor(360·k/Q) degrees. For x < 180, with u = x·(180−x), the entry is floor(2047·4u/(40500−u)). For x ≥ 180, the entry is the negative of the value for x−180. Entries are signed 12-bit.
- R3: The control value is v = (entry·amp) arithmetically shifted right by (19 − log2(L/2)), which is 14 for the default L = 64. The shift floors toward minus infinity. The result is clamped to the range −L/2 to +L/2. `amp` is an unsigned 8-bit fraction.
- R4: The carrier count runs from 0 to L−1 and wraps, giving L clocks per carrier period. The centred ramp is r = count − L/2. Carrier period k after enable uses the control value of table entry k mod Q. The entry advances once per wrap.
- R5: The first arm's high request is v > r. Its low request is the complement.
- R6: The second arm's high request is −v > r. Its low request is the complement. The two arms' high requests therefore last L/2+v and L/2−v clocks per period, which sum to L.
- R7: Gates follow the requests one clock later. Between one side of an arm turning off and the other side turning on, both are off for D clocks (default D = 2). When both request regions are longer than D, each period has the following on-counts: `a_hi` and `b_lo` are each on for L/2+v−D clocks, and `a_lo` and `b_hi` are each on for L/2−v−D clocks.
- R8: The positive drive window (`a_hi` and `b_lo` both on) lasts max(0, 2v−D) clocks per period. The negative window (`a_lo` and `b_hi` both on) lasts max(0, −2v−D) clocks. Counting the clock after the period's first count as position 1, the positive window starts at position L/2−v+1+D and the negative window starts at position L/2+v+1+D, so both are centred in the period.
- R9: The high and low gates of one arm are never on together.
- R10: `cyc_start` is 1 exactly when enabled at carrier count 0 of table entry 0. While running, this happens once every Q·L clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low parks the bridge and rewinds |
| amp | input | 8 | Unsigned amplitude fraction (amp/256) |
| a_hi | output | 1 | First arm high-side gate |
| a_lo | output | 1 | First arm low-side gate |
| b_hi | output | 1 | Second arm high-side gate |
| b_lo | output | 1 | Second arm low-side gate |
| cyc_start | output | 1 | First clock of each output cycle |

## Verification
The hardest part to reach from the ports is attributing each gate pulse to the carrier period that produced it, because the counter and the control value are internal. The stimulus solves this by raising enable at a known clock, where `cyc_start` marks count 0 of entry 0. It then counts gate activity in L-clock windows shifted by one clock. Inside each window the on-counts, the overlap lengths and the overlap start positions can all be predicted from the table formula. Amplitudes are chosen so that every request region stays longer than the dead time, and zero amplitude exercises the case where neither overlap window opens.

// File: rtl/spwm_pkg.sv
`timescale 1ns/1ps
package spwm_pkg;
    localparam int SAMPLE_W = 12;
    localparam int AMP_W    = 8;

    typedef enum logic [2:0] {
        G_OFF   = 3'd0,
        G_LO    = 3'd1,
        G_DT_HI = 3'd2,
        G_HI    = 3'd3,
        G_DT_LO = 3'd4
    } gate_st_e;

    // Rational sine approximation over one full cycle of q entries
    function automatic logic signed [SAMPLE_W-1:0] sine_sample(input int k, input int q);
        int x, base, u, mag, sgn;
        x = (360 * k) / q;
        if (x >= 180) begin
            base = x - 180;
            sgn  = -1;
        end else begin
            base = x;
            sgn  = 1;
        end
        u   = base * (180 - base);
        mag = (2047 * 4 * u) / (40500 - u);
        return SAMPLE_W'(sgn * mag);
    endfunction
endpackage

// File: rtl/spwm_carrier.sv
`timescale 1ns/1ps
module spwm_carrier #(
    parameter int RAMP_LEN = 64,
    parameter int SAMPLES  = 40
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    output logic [$clog2(RAMP_LEN)-1:0]  cnt,
    output logic [$clog2(SAMPLES)-1:0]   idx,
    output logic [$clog2(SAMPLES)-1:0]   nidx,
    output logic                         wrap,
    output logic                         cyc_start
);
    localparam int RW = $clog2(RAMP_LEN);
    localparam int IW = $clog2(SAMPLES);
    localparam logic [RW-1:0] LAST = RW'(RAMP_LEN - 1);
    localparam logic [IW-1:0] ILAST = IW'(SAMPLES - 1);

    assign wrap      = en && (cnt == LAST);
    assign nidx      = (idx == ILAST) ? '0 : idx + 1'b1;
    assign cyc_start = en && (cnt == '0) && (idx == '0);

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            idx <= '0;
        end else begin
            cnt <= wrap ? '0 : cnt + 1'b1;
            if (wrap) idx <= nidx;
        end
    end

    // R4: the table position moves only onto a fresh carrier period
    p_idx_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (idx != $past(idx)) |-> (cnt == '0));
    p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= ILAST);
endmodule

// File: rtl/spwm_ctl.sv
`timescale 1ns/1ps
module spwm_ctl import spwm_pkg::*; #(
    parameter int RAMP_LEN = 64,
    parameter int SAMPLES  = 40
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              en,
    input  logic                              wrap,
    input  logic [$clog2(SAMPLES)-1:0]        nidx,
    input  logic [AMP_W-1:0]                  amp,
    output logic signed [$clog2(RAMP_LEN):0]  ctl
);
    localparam int RW    = $clog2(RAMP_LEN);
    localparam int HALF  = RAMP_LEN / 2;
    localparam int PW    = SAMPLE_W + AMP_W + 1;
    localparam int SHIFT = (SAMPLE_W - 1) + AMP_W - $clog2(HALF);
    localparam logic signed [PW-1:0] POS_LIM = PW'(HALF);
    localparam logic signed [PW-1:0] NEG_LIM = -PW'(HALF);

    logic signed [SAMPLE_W-1:0] tbl [SAMPLES];
    logic signed [SAMPLE_W-1:0] samp;
    logic signed [PW-1:0]       prod, scaled;
    logic signed [RW:0]         ctl_d;

    for (genvar g = 0; g < SAMPLES; g++) begin : g_tbl
        assign tbl[g] = sine_sample(g, SAMPLES);
    end

    assign samp   = tbl[nidx];
    assign prod   = $signed({{(PW-SAMPLE_W){samp[SAMPLE_W-1]}}, samp})
                  * $signed({{(PW-AMP_W){1'b0}}, amp});
    assign scaled = prod >>> SHIFT;

    always_comb begin
        if (scaled > POS_LIM)      ctl_d = (RW+1)'(HALF);
        else if (scaled < NEG_LIM) ctl_d = -(RW+1)'(HALF);
        else                       ctl_d = scaled[RW:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !en) ctl <= '0;
        else if (wrap)     ctl <= ctl_d;
    end

    // R3: control value stays within the carrier span
    p_ctl_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl <= (RW+1)'(HALF)) && (ctl >= -(RW+1)'(HALF)));
    // R4: one control value per carrier period
    p_ctl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wrap) |=> $stable(ctl));
endmodule

// File: rtl/spwm_arm.sv
`timescale 1ns/1ps
module spwm_arm import spwm_pkg::*; #(
    parameter int RAMP_LEN = 64,
    parameter int DEAD_CYC = 2,
    parameter bit NEGATE   = 1'b0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              en,
    input  logic [$clog2(RAMP_LEN)-1:0]       cnt,
    input  logic signed [$clog2(RAMP_LEN):0]  ctl,
    output logic                              hi,
    output logic                              lo
);
    localparam int RW   = $clog2(RAMP_LEN);
    localparam int HALF = RAMP_LEN / 2;
    localparam int DW   = $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0] DLOAD = DW'(DEAD_CYC - 1);

    logic signed [RW+1:0] ref_v, ramp_s;
    logic                 want_hi;
    gate_st_e             state, nstate;
    logic [DW-1:0]        dcnt, ndcnt;

    if (NEGATE) begin : g_neg
        assign ref_v = -$signed({ctl[RW], ctl});
    end else begin : g_pos
        assign ref_v = $signed({ctl[RW], ctl});
    end

    assign ramp_s  = $signed({2'b00, cnt}) - $signed((RW+2)'(HALF));
    assign want_hi = ref_v > ramp_s;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= G_OFF;
            dcnt  <= '0;
        end else begin
            state <= nstate;
            dcnt  <= ndcnt;
        end
    end

    always_comb begin
        nstate = state;
        ndcnt  = dcnt;
        if (!en) begin
            nstate = G_OFF;
            ndcnt  = '0;
        end else begin
            unique case (state)
                G_OFF: begin
                    nstate = want_hi ? G_DT_HI : G_DT_LO;
                    ndcnt  = DLOAD;
                end
                G_LO: if (want_hi) begin
                    nstate = G_DT_HI;
                    ndcnt  = DLOAD;
                end
                G_DT_HI: begin
                    if (!want_hi)         nstate = G_LO;
                    else if (dcnt == '0)  nstate = G_HI;
                    else                  ndcnt  = dcnt - 1'b1;
                end
                G_HI: if (!want_hi) begin
                    nstate = G_DT_LO;
                    ndcnt  = DLOAD;
                end
                G_DT_LO: begin
                    if (want_hi)          nstate = G_HI;
                    else if (dcnt == '0)  nstate = G_LO;
                    else                  ndcnt  = dcnt - 1'b1;
                end
                default: nstate = G_OFF;
            endcase
        end
    end

    always_comb begin
        hi = (state == G_HI);
        lo = (state == G_LO);
    end

    p_no_shoot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi && lo));
    p_gap_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi) |-> !$past(lo));
    p_gap_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo) |-> !$past(hi));
    p_off_dis_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!hi && !lo));
endmodule

// File: rtl/spwm_hbridge.sv
`timescale 1ns/1ps
module spwm_hbridge import spwm_pkg::*; #(
    parameter int RAMP_LEN = 64,
    parameter int SAMPLES  = 40,
    parameter int DEAD_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [7:0] amp,
    output logic       a_hi,
    output logic       a_lo,
    output logic       b_hi,
    output logic       b_lo,
    output logic       cyc_start
);
    localparam int RW = $clog2(RAMP_LEN);
    localparam int IW = $clog2(SAMPLES);

    logic [RW-1:0]      cnt;
    logic [IW-1:0]      idx, nidx;
    logic               wrap;
    logic signed [RW:0] ctl;

    spwm_carrier #(.RAMP_LEN(RAMP_LEN), .SAMPLES(SAMPLES)) u_car (
        .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt), .idx(idx),
        .nidx(nidx), .wrap(wrap), .cyc_start(cyc_start));

    spwm_ctl #(.RAMP_LEN(RAMP_LEN), .SAMPLES(SAMPLES)) u_ctl (
        .clk(clk), .rst_n(rst_n), .en(en), .wrap(wrap), .nidx(nidx),
        .amp(amp), .ctl(ctl));

    spwm_arm #(.RAMP_LEN(RAMP_LEN), .DEAD_CYC(DEAD_CYC), .NEGATE(1'b0)) u_arm_a (
        .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt), .ctl(ctl),
        .hi(a_hi), .lo(a_lo));

    spwm_arm #(.RAMP_LEN(RAMP_LEN), .DEAD_CYC(DEAD_CYC), .NEGATE(1'b1)) u_arm_b (
        .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt), .ctl(ctl),
        .hi(b_hi), .lo(b_lo));

    // R10: strobe only at the start of table entry 0
    p_strobe_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |-> (idx == '0));
endmodule

// File: tb/tb_spwm_hbridge.sv
`timescale 1ns/1ps
module tb_spwm_hbridge;
    localparam int L     = 64;
    localparam int Q     = 40;
    localparam int D     = 2;
    localparam int HALF  = L / 2;
    localparam int SHIFT = 19 - $clog2(HALF);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [7:0] amp = 8'd0;
    logic a_hi, a_lo, b_hi, b_lo, cyc_start;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spwm_hbridge #(.RAMP_LEN(L), .SAMPLES(Q), .DEAD_CYC(D)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .amp(amp),
        .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
        .cyc_start(cyc_start));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sine_ref(input int k);
        int x, b, u, m;
        x = (360 * k) / Q;
        b = (x >= 180) ? x - 180 : x;
        u = b * (180 - b);
        m = (2047 * 4 * u) / (40500 - u);
        return (x >= 180) ? -m : m;
    endfunction

    function automatic int v_ref(input int k, input int a);
        int p, v;
        p = sine_ref(k) * a;
        v = p >>> SHIFT;
        if (v > HALF) v = HALF;
        if (v < -HALF) v = -HALF;
        return v;
    endfunction

    function automatic int pos0(input int x);
        return (x > 0) ? x : 0;
    endfunction

    // R1: reset holds everything off
    task automatic t_reset();
        @(negedge clk);
        chk({a_hi, a_lo, b_hi, b_lo} == 4'b0, "R1", "gates in reset",
            int'({a_hi, a_lo, b_hi, b_lo}), 0);
        chk(cyc_start == 1'b0, "R1", "strobe in reset", int'(cyc_start), 0);
    endtask

    // R1: idle while disabled
    task automatic t_idle();
        int on_cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (a_hi || a_lo || b_hi || b_lo || cyc_start) on_cnt++;
        end
        chk(on_cnt == 0, "R1", "activity while disabled", on_cnt, 0);
    endtask

    // R2 R3 R4 R5 R6 R7 R8 R9 R10: one full output cycle at amplitude a
    task automatic t_cycle(input int a);
        int ah, al, bh, bl, po, ne, fpo, fne, shoot, cs_early, v;
        int e_hi, e_lo, e_po, e_ne, e_fpo, e_fne;
        bit ok;
        amp = 8'(a);
        @(negedge clk);
        en = 1'b1;
        #1;
        chk(cyc_start == 1'b1, "R10", "strobe at enable", int'(cyc_start), 1);
        shoot = 0;
        cs_early = 0;
        ah = 0; al = 0; bh = 0; bl = 0; po = 0; ne = 0; fpo = 0; fne = 0;
        for (int i = 1; i <= Q * L; i++) begin
            int j;
            @(negedge clk);
            j = (i - 1) % L + 1;
            if ((a_hi && a_lo) || (b_hi && b_lo)) shoot++;
            if (cyc_start && i != Q * L) cs_early++;
            if (i == Q * L)
                chk(cyc_start == 1'b1, "R10", "strobe after Q*L clocks", int'(cyc_start), 1);
            ah += int'(a_hi); al += int'(a_lo); bh += int'(b_hi); bl += int'(b_lo);
            if (a_hi && b_lo) begin po++; if (fpo == 0) fpo = j; end
            if (a_lo && b_hi) begin ne++; if (fne == 0) fne = j; end
            if (j == L) begin
                v = v_ref((i - 1) / L, a);
                e_hi = HALF + v - D;
                e_lo = HALF - v - D;
                ok = (ah == e_hi) && (bl == e_hi) && (al == e_lo) && (bh == e_lo);
                chk(ok, "R2 R3 R4 R5 R6 R7", $sformatf("on counts ah/bl/al/bh=%0d/%0d/%0d/%0d period %0d",
                    ah, bl, al, bh, (i - 1) / L), ah * 1000 + al, e_hi * 1000 + e_lo);
                e_po  = pos0(2 * v - D);
                e_ne  = pos0(-2 * v - D);
                e_fpo = (e_po > 0) ? HALF - v + 1 + D : 0;
                e_fne = (e_ne > 0) ? HALF + v + 1 + D : 0;
                ok = (po == e_po) && (ne == e_ne) && (fpo == e_fpo) && (fne == e_fne);
                chk(ok, "R8", $sformatf("overlap pos/neg len, starts %0d/%0d period %0d",
                    fpo, fne, (i - 1) / L), po * 1000 + ne, e_po * 1000 + e_ne);
                ah = 0; al = 0; bh = 0; bl = 0; po = 0; ne = 0; fpo = 0; fne = 0;
            end
        end
        chk(shoot == 0, "R9", "arm shoot-through clocks", shoot, 0);
        chk(cs_early == 0, "R10", "extra strobes", cs_early, 0);
        en = 1'b0;
        @(negedge clk);
        chk({a_hi, a_lo, b_hi, b_lo} == 4'b0, "R1", "gates after disable",
            int'({a_hi, a_lo, b_hi, b_lo}), 0);
        repeat (4) @(negedge clk);
    endtask

    // R1: disable mid-cycle rewinds the table position
    task automatic t_mid_disable();
        amp = 8'd150;
        @(negedge clk);
        en = 1'b1;
        repeat (300) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk({a_hi, a_lo, b_hi, b_lo} == 4'b0, "R1", "gates one clock after mid disable",
            int'({a_hi, a_lo, b_hi, b_lo}), 0);
        repeat (5) @(negedge clk);
        en = 1'b1;
        #1;
        chk(cyc_start == 1'b1, "R1", "rewound to entry 0 on re-enable", int'(cyc_start), 1);
        @(negedge clk);
        chk({a_hi, a_lo, b_hi, b_lo} == 4'b0, "R7", "dead clocks after re-enable",
            int'({a_hi, a_lo, b_hi, b_lo}), 0);
        en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_idle();
        t_cycle(200);
        t_cycle(100);
        t_cycle(0);
        t_mid_disable();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run completion)");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule